// File: doc/BRIEF.md
# Trace Unit Programming Controller

This block is the register-mapped control front end of an instruction trace unit. Software talks to it over a simple register bus made of a word address, write data and a write strobe, and it reads back through a combinational read-data port. At reset the block is guarded by an operating-system lock, and no control or configuration state can change until software writes the unlock register. Once unlocked, software can set a power-up request and a trace enable bit, and it can load a small bank of configuration registers that feed the trace engine.

A stub trace engine models the start-up and drain latency of real trace hardware. Setting the enable bit moves it out of idle, through a start-up phase lasting a parameterised number of cycles, and into running. Clearing the bit sends it through a drain phase, also of parameterised length, in which outstanding trace activity completes. Only after that does the idle flag return. Configuration writes take effect only while the lock is released and the engine is idle. Software therefore follows a fixed sequence: clear enable, poll the idle bit until it is set, reprogram, then set enable again.

Register offsets (word addresses): 0 control (bit 0 enable), 1 status (read only), 2 unlock, 3 lock, 4 power (bit 0 power-up request), 8 and above are the configuration registers, one per index.

Top module: `trace_prog_ctrl`

## Requirements
- R1: After reset the lock is set, the enable and power bits are 0, every configuration register is 0, the engine is idle, and the status register reads 3.
- R2: A write of any data value to address 2 releases the lock, and status bit 1 then reads 0.
- R3: A write to address 3 with data bit 0 equal to 1 sets the lock again. A write there with data bit 0 equal to 0 leaves the lock unchanged.
- R4: While the lock is set, writes to the control register (address 0), the power register (address 4) and the configuration registers are ignored.
- R5: When bit 0 of address 0 is written to 1 from idle, the idle flag falls on the clock edge after the write edge. The running flag rises START_CYC edges after that.
- R6: When the enable bit is cleared, running falls on the edge after the write edge and draining rises on the same edge. Draining lasts exactly DRAIN_CYC cycles, and idle rises as draining ends.
- R7: A write to a configuration register (address 8 + index) is accepted only while the lock is released and the engine is idle. It is ignored while the engine is starting, running or draining.
- R8: Bit 0 of a write to address 4 sets or clears the power-up request. The request drives power_req_o and reads back in bit 0 of address 4.
- R9: The status register (address 1) returns idle in bit 0 and the lock state in bit 1, with all other bits 0. Writes to it have no effect.
- R10: Address 0 reads the enable bit in bit 0, each configuration address reads its stored value, and any unmapped address reads 0.
- R11: If enable is set again while the engine drains, the drain completes and idle reads 1 for one cycle. The engine then starts again and runs START_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| trace_en_o | output | 1 | Stored trace enable bit |
| idle_o | output | 1 | Engine idle; configuration may change |
| running_o | output | 1 | Engine generating trace |
| draining_o | output | 1 | Engine completing outstanding activity |
| power_req_o | output | 1 | Request to keep the trace unit powered |
| os_locked_o | output | 1 | Lock state |
| cfg_o | output | NCFG*DATA_W | Configuration registers, index 0 in the low bits |

## Verification
The bench builds the block with START_CYC of 3, DRAIN_CYC of 5, four 16-bit configuration registers and a 4-bit address. The short latencies let exact edge-by-edge checks of both handshakes fit next to each other. They also leave room to land a configuration write inside the drain window and a re-enable in the middle of a drain. A 4-bit address covers the whole map, so random traffic reaches every register, the status register and the unmapped holes at 5 to 7 and 12 to 15.

// File: rtl/tpc_pkg.sv
// Shared definitions for the trace unit programming controller.
// Assumes word addressing; offsets below are fixed by the software sequence.
package tpc_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_START = 2'd1,
        ENG_RUN   = 2'd2,
        ENG_DRAIN = 2'd3
    } eng_state_t;

    localparam int OFS_CTRL   = 0;
    localparam int OFS_STATUS = 1;
    localparam int OFS_UNLOCK = 2;
    localparam int OFS_LOCK   = 3;
    localparam int OFS_POWER  = 4;
    localparam int OFS_CFG    = 8;

endpackage

// File: rtl/tpc_lock.sv
// OS-level access lock. Set at reset; released by any unlock write;
// set again by a lock write carrying 1 in bit 0.
// Assumes unlock and lock strobes are never high together (distinct addresses).
module tpc_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_wr_i,
    input  logic lock_wr_i,
    input  logic lock_bit_i,
    output logic locked_o
);

    logic locked_q;

    // Lock state register with release priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b1;
        else if (unlock_wr_i)
            locked_q <= 1'b0;
        else if (lock_wr_i && lock_bit_i)
            locked_q <= 1'b1;
    end

    assign locked_o = locked_q;

    assert_unlock_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_wr_i |=> !locked_o);

    assert_lock_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr_i && lock_bit_i) |=> locked_o);

    assert_lock_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr_i && !lock_bit_i && !unlock_wr_i) |=> $stable(locked_o));

endmodule

// File: rtl/tpc_engine.sv
// Stub trace engine: models start-up and drain latency around the enable bit.
// Idle only once a drain has fully completed; starting can be aborted into drain.
// Assumes START_CYC >= 1 and DRAIN_CYC >= 1.
module tpc_engine
    import tpc_pkg::*;
#(
    parameter int START_CYC = 4,
    parameter int DRAIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    output logic idle_o,
    output logic running_o,
    output logic draining_o
);

    localparam int CNT_MAX = (START_CYC > DRAIN_CYC) ? START_CYC : DRAIN_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYC - 1);
    localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_CYC - 1);

    eng_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and phase counter selection.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (enable_i) begin
                    state_d = ENG_START;
                    cnt_d   = '0;
                end
            end
            ENG_START: begin
                if (!enable_i) begin
                    state_d = ENG_DRAIN;
                    cnt_d   = '0;
                end else if (cnt_q == START_LAST) begin
                    state_d = ENG_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ENG_RUN: begin
                if (!enable_i) begin
                    state_d = ENG_DRAIN;
                    cnt_d   = '0;
                end
            end
            ENG_DRAIN: begin
                if (cnt_q == DRAIN_LAST) begin
                    state_d = ENG_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ENG_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign idle_o     = (state_q == ENG_IDLE);
    assign running_o  = (state_q == ENG_RUN);
    assign draining_o = (state_q == ENG_DRAIN);

    assert_idle_leaves_on_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_o) |-> $past(enable_i));

    assert_run_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> $past(!idle_o && !draining_o && enable_i));

    assert_idle_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(draining_o));

    assert_run_stops_to_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !enable_i) |=> draining_o);

    assert_drain_holds_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (draining_o && enable_i) |=> (draining_o || idle_o));

endmodule

// File: rtl/tpc_cfg_bank.sv
// Bank of configuration registers written one at a time by index.
// Assumes the caller has already applied lock and idle gating to wr_en_i.
module tpc_cfg_bank #(
    parameter int NCFG   = 4,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    output logic [NCFG*DATA_W-1:0] cfg_o
);

    localparam int IDX_W = (NCFG > 1) ? $clog2(NCFG) : 1;

    for (genvar g = 0; g < NCFG; g++) begin : g_reg
        logic [DATA_W-1:0] val_q;

        // One configuration word, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
                val_q <= wr_data_i;
        end

        assign cfg_o[g*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/trace_prog_ctrl.sv
// Trace unit programming controller top: register decode, control and power
// bits, write gating and read multiplexer around the lock, engine and bank.
// Assumes one register access per cycle, NCFG <= 2**ADDR_W - 8, ADDR_W >= 4.
module trace_prog_ctrl
    import tpc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int NCFG      = 4,
    parameter int START_CYC = 4,
    parameter int DRAIN_CYC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic                   we_i,
    output logic [DATA_W-1:0]      rdata_o,
    output logic                   trace_en_o,
    output logic                   idle_o,
    output logic                   running_o,
    output logic                   draining_o,
    output logic                   power_req_o,
    output logic                   os_locked_o,
    output logic [NCFG*DATA_W-1:0] cfg_o
);

    localparam int IDX_W = (NCFG > 1) ? $clog2(NCFG) : 1;
    localparam int CMP_W = ADDR_W + 1;

    // Address decode.
    logic hit_ctrl, hit_status, hit_unlock, hit_lock, hit_power, hit_cfg;
    logic [IDX_W-1:0] cfg_idx;

    assign hit_ctrl   = (addr_i == ADDR_W'(OFS_CTRL));
    assign hit_status = (addr_i == ADDR_W'(OFS_STATUS));
    assign hit_unlock = (addr_i == ADDR_W'(OFS_UNLOCK));
    assign hit_lock   = (addr_i == ADDR_W'(OFS_LOCK));
    assign hit_power  = (addr_i == ADDR_W'(OFS_POWER));
    assign hit_cfg    = ({1'b0, addr_i} >= CMP_W'(OFS_CFG)) &&
                        ({1'b0, addr_i} <  CMP_W'(OFS_CFG + NCFG));
    assign cfg_idx    = IDX_W'(addr_i - ADDR_W'(OFS_CFG));

    logic locked, en_q, pwr_q;
    logic ctrl_wr_ok, cfg_wr_ok;

    assign ctrl_wr_ok = we_i && !locked;
    assign cfg_wr_ok  = we_i && hit_cfg && !locked && idle_o;

    tpc_lock u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .unlock_wr_i (we_i && hit_unlock),
        .lock_wr_i   (we_i && hit_lock),
        .lock_bit_i  (wdata_i[0]),
        .locked_o    (locked)
    );

    // Trace enable bit, writable whenever unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (ctrl_wr_ok && hit_ctrl)
            en_q <= wdata_i[0];
    end

    // Power-up request bit, writable whenever unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwr_q <= 1'b0;
        else if (ctrl_wr_ok && hit_power)
            pwr_q <= wdata_i[0];
    end

    tpc_engine #(
        .START_CYC (START_CYC),
        .DRAIN_CYC (DRAIN_CYC)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (en_q),
        .idle_o     (idle_o),
        .running_o  (running_o),
        .draining_o (draining_o)
    );

    tpc_cfg_bank #(
        .NCFG   (NCFG),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_wr_ok),
        .wr_idx_i  (cfg_idx),
        .wr_data_i (wdata_i),
        .cfg_o     (cfg_o)
    );

    // Select the configuration word addressed by cfg_idx.
    logic [DATA_W-1:0] cfg_sel;
    always_comb begin
        cfg_sel = '0;
        for (int i = 0; i < NCFG; i++) begin
            if (cfg_idx == IDX_W'(i))
                cfg_sel = cfg_o[i*DATA_W +: DATA_W];
        end
    end

    // Read multiplexer; unmapped and write-only addresses return zero.
    always_comb begin
        rdata_o = '0;
        if (hit_ctrl)
            rdata_o = DATA_W'(en_q);
        else if (hit_status)
            rdata_o = DATA_W'({locked, idle_o});
        else if (hit_power)
            rdata_o = DATA_W'(pwr_q);
        else if (hit_cfg)
            rdata_o = cfg_sel;
    end

    assign trace_en_o  = en_q;
    assign power_req_o = pwr_q;
    assign os_locked_o = locked;

    assert_cfg_frozen_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        os_locked_o |=> $stable(cfg_o));

    assert_ctrl_frozen_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        os_locked_o |=> ($stable(trace_en_o) && $stable(power_req_o)));

    assert_cfg_frozen_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |=> $stable(cfg_o));

    assert_power_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_power && !os_locked_o) |=> (power_req_o == $past(wdata_i[0])));

endmodule

// File: tb/trace_prog_ctrl_test.sv
module trace_prog_ctrl_test;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int NCFG   = 4;
    localparam int SC     = 3;
    localparam int DC     = 5;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [ADDR_W-1:0]      addr;
    logic [DATA_W-1:0]      wdata;
    logic                   we;
    logic [DATA_W-1:0]      rdata;
    logic                   trace_en, idle, running, draining, power_req, locked;
    logic [NCFG*DATA_W-1:0] cfg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of architectural state.
    logic              m_lock, m_en, m_pwr;
    logic [DATA_W-1:0] m_cfg [NCFG];

    always #4 clk = ~clk;

    trace_prog_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NCFG      (NCFG),
        .START_CYC (SC),
        .DRAIN_CYC (DC)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .we_i        (we),
        .rdata_o     (rdata),
        .trace_en_o  (trace_en),
        .idle_o      (idle),
        .running_o   (running),
        .draining_o  (draining),
        .power_req_o (power_req),
        .os_locked_o (locked),
        .cfg_o       (cfg)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
        if (a == 0) return DATA_W'(m_en);
        if (a == 1) return DATA_W'({m_lock, !m_en});
        if (a == 4) return DATA_W'(m_pwr);
        if (a >= 8 && a < 8 + NCFG) return m_cfg[a - 8];
        return '0;
    endfunction

    // Model update for a write issued after the engine has settled.
    task automatic model_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        if (a == 0 && !m_lock) m_en = d[0];
        else if (a == 2) m_lock = 1'b0;
        else if (a == 3 && d[0]) m_lock = 1'b1;
        else if (a == 4 && !m_lock) m_pwr = d[0];
        else if (a >= 8 && a < 8 + NCFG && !m_lock && !m_en) m_cfg[a - 8] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] v;
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        step(4);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        rd(1, v);  chk("R1", "status", v, 3);
        rd(0, v);  chk("R1", "ctrl", v, 0);
        rd(4, v);  chk("R1", "power", v, 0);
        chk("R1", "cfg bus", cfg, 0);
        chk("R1", "idle/locked", {idle, locked, trace_en, power_req}, 4'b1100);

        // R4: writes ignored while locked
        wr(0, 1); wr(4, 1); wr(8, 16'hABCD);
        step(SC + 3);
        chk("R4", "enable locked", trace_en, 0);
        chk("R4", "power locked", power_req, 0);
        chk("R4", "idle locked", idle, 1);
        rd(8, v);  chk("R4", "cfg0 locked", v, 0);

        // R2 / R3: unlock and relock
        wr(2, 16'h5A5A);
        rd(1, v);  chk("R2", "status after unlock", v, 1);
        wr(3, 16'h0002);
        rd(1, v);  chk("R3", "lock bit0=0", v, 1);
        wr(3, 16'h0001);
        rd(1, v);  chk("R3", "lock bit0=1", v, 3);
        wr(2, 16'h0000);
        rd(1, v);  chk("R2", "unlock zero data", v, 1);

        // R9: status is read only
        wr(1, 16'hFFFF);
        rd(1, v);  chk("R9", "status after write", v, 1);

        // R7 / R10: idle config write, read map
        wr(9, 16'h1234);
        rd(9, v);  chk("R7", "cfg1 idle write", v, 16'h1234);
        chk("R10", "cfg bus word1", cfg[DATA_W +: DATA_W], 16'h1234);
        rd(5, v);  chk("R10", "unmapped 5", v, 0);
        rd(14, v); chk("R10", "unmapped 14", v, 0);

        // R8: power request
        wr(4, 16'hFFFF);
        chk("R8", "power_req", power_req, 1);
        rd(4, v);  chk("R8", "power read", v, 1);

        // R5: enable handshake
        wr(0, 1);
        chk("R5", "idle on write edge", idle, 1);
        rd(0, v);  chk("R10", "ctrl read", v, 1);
        step(1);
        chk("R5", "idle fell", idle, 0);
        step(SC - 1);
        chk("R5", "not yet running", running, 0);
        step(1);
        chk("R5", "running", running, 1);

        // R7: config write ignored while running
        wr(10, 16'h7777);
        rd(10, v); chk("R7", "cfg2 running", v, 0);

        // R6: disable and drain, with a config write inside the drain
        wr(0, 0);
        chk("R6", "still running on write edge", running, 1);
        step(1);
        chk("R6", "drain/run/idle", {draining, running, idle}, 3'b100);
        wr(10, 16'h6666);
        step(DC - 2);
        chk("R6", "idle before drain end", idle, 0);
        chk("R6", "draining at end", draining, 1);
        step(1);
        chk("R6", "idle after drain", {idle, draining}, 2'b10);
        rd(10, v); chk("R7", "cfg2 draining", v, 0);
        rd(1, v);  chk("R9", "status idle unlocked", v, 1);

        // R11: re-enable during drain
        wr(0, 1);
        step(SC + 1);
        chk("R11", "running before", running, 1);
        wr(0, 0);
        step(1);
        wr(0, 1);
        step(DC - 1);
        chk("R11", "idle after drain", idle, 1);
        step(1);
        chk("R11", "restarting", idle, 0);
        step(SC - 1);
        chk("R11", "not yet running", running, 0);
        step(1);
        chk("R11", "running again", running, 1);
        wr(0, 0);
        step(DC + 2);
        chk("R11", "settled idle", idle, 1);

        // Random traffic against the bench model.
        m_lock = 1'b0; m_en = 1'b0; m_pwr = 1'b1;
        m_cfg[0] = '0; m_cfg[1] = 16'h1234; m_cfg[2] = '0; m_cfg[3] = '0;
        for (int n = 0; n < 200; n++) begin
            logic [ADDR_W-1:0] a, ra;
            logic [DATA_W-1:0] d;
            a  = ADDR_W'($urandom % 16);
            d  = DATA_W'($urandom);
            ra = ADDR_W'($urandom % 16);
            wr(a, d);
            model_wr(a, d);
            if (a == 0) step(SC + DC + 3);
            rd(1, v);  chk("R9", "random status", v, exp_read(1));
            rd(ra, v); chk("R10", "random read", v, exp_read(ra));
            chk("R4", "random outputs", {locked, trace_en, power_req},
                {m_lock, m_en, m_pwr});
            chk("R7", "random cfg bus",
                cfg, {m_cfg[3], m_cfg[2], m_cfg[1], m_cfg[0]});
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule